// File: doc/BRIEF.md
# Write Unlock Sequence Detector

This block sits in front of the page loader of a byte-wide nonvolatile memory and decides what each bus write means. Protection cannot be switched off, so before any data byte reaches the array the host must issue a fixed preamble of three command writes, each with its own address and data value. Once the third command write lands, the detector opens the write path for one load period. Every data write in that period is passed to the loader as a "store" write. The loader's commit closes the path again.

Any write that arrives without the full preamble, or that breaks the preamble, is still passed to the loader, but marked "timer only". The loader then runs its write-cycle timer and answers reads with status-polling values for that time, while storing nothing. Command writes are consumed here and never reach the loader.

Two hardware guards are included. The first is a power-up hold-off: writes are ignored for a set number of cycles after the supply-good input asserts, and again whenever it drops. The second is a strobe filter that ignores write pulses shorter than a set number of clock cycles. A write is recognised when chip enable and write enable are both low while output enable is high. Address and data are taken from the last cycle the strobe was active, and the write is acted on in the cycle the strobe ends.

Top module: `unlock_seq_detector`

## Requirements
- R1: After reset, `unlocked` and `loadStrobe` are 0.
- R2: While `supplyGood` is low, and for `PWRUP_CYC` clock cycles after it rises, writes produce no `loadStrobe` and do not advance the command sequence.
- R3: A strobe active (ceN=0, weN=0, oeN=1) for fewer than `GLITCH_CYC` consecutive cycles is ignored. One active for `GLITCH_CYC` or more cycles is a write.
- R4: If oeN goes low while the strobe is active, that strobe is cancelled and produces no write.
- R5: The writes (CMD_ADDR[0],CMD_DATA[0]), (CMD_ADDR[1],CMD_DATA[1]), (CMD_ADDR[2],CMD_DATA[2]) in that order set `unlocked` to 1 in the cycle after the third strobe ends. These writes produce no `loadStrobe`. The defaults are 0x5555/0xAA, 0x2AAA/0x55 and 0x5555/0xA0.
- R6: While locked, a write that is not the expected next command produces a `loadStrobe` with `loadStore`=0 and returns the sequence to its first step.
- R7: While unlocked, every write produces a `loadStrobe` with `loadStore`=1.
- R8: A `loadCommit` pulse while unlocked clears `unlocked` in the next cycle, and the write after it is rejected.
- R9: `loadStrobe` is high for exactly one cycle per accepted write, in the cycle after the strobe ends.
- R10: With each `loadStrobe`, `evtAddr` and `evtData` carry the address and data of that write's last active strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyGood | input | 1 | Supply within range |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus write data |
| loadCommit | input | 1 | Loader has committed the load period |
| unlocked | output | 1 | Write path open for storing |
| loadStrobe | output | 1 | One-cycle pulse per write handed to the loader |
| loadStore | output | 1 | With loadStrobe: 1 store data, 0 run timer only |
| evtAddr | output | ADDR_W | Address of the handed-over write |
| evtData | output | DATA_W | Data of the handed-over write |

## Verification
A wrong sequence state shows up at the ports on the very next write. Either `unlocked` rises without the full preamble, or a store-marked `loadStrobe` appears where a timer-only one is expected, or the reverse. A counter fault in the strobe filter or the power-up hold-off makes a write appear or vanish one cycle after a strobe whose width or timing sits right at the threshold. The bench therefore sweeps pulse widths across the limit, breaks the preamble at every step, and writes at once after supply-good rises.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_STEP0 = 2'd0,
    SEQ_STEP1 = 2'd1,
    SEQ_STEP2 = 2'd2,
    SEQ_OPEN  = 2'd3
  } seqState_e;

  typedef struct packed {
    logic issue;   // hand the current write to the loader
    logic store;   // store data (1) or timer only (0)
  } ctlStrobes_t;
endpackage

// File: rtl/unlock_seq_datapath.sv
module unlock_seq_datapath
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 2,
  parameter int PWRUP_CYC  = 625000,
  parameter logic [2:0][ADDR_W-1:0] CMD_ADDR = {17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [2:0][DATA_W-1:0] CMD_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  ctlStrobes_t       ctl,
  output logic              relEvt,
  output logic [2:0]        cmdHit,
  output logic              ready,
  output logic              loadStrobe,
  output logic              loadStore,
  output logic [ADDR_W-1:0] evtAddr,
  output logic [DATA_W-1:0] evtData
);
  localparam int PW_W = $clog2(GLITCH_CYC + 1);
  localparam int PU_W = $clog2(PWRUP_CYC + 1);
  localparam logic [PW_W-1:0] PW_MAX = PW_W'(GLITCH_CYC);
  localparam logic [PU_W-1:0] PU_MAX = PU_W'(PWRUP_CYC);

  logic              strobeOn;
  logic              strobeOk;
  logic [PW_W-1:0]   pulseCnt;
  logic [PU_W-1:0]   pwrCnt;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;

  assign strobeOn = !ceN && !weN;
  assign strobeOk = strobeOn && oeN;

  // Pulse-width filter: counts consecutive good strobe cycles, saturating.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobeOk) begin
      if (pulseCnt != PW_MAX) pulseCnt <= pulseCnt + 1'b1;
    end else begin
      pulseCnt <= '0;
    end
  end

  // Address and data of the most recent good strobe cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
    end else if (strobeOk) begin
      capAddr <= addr;
      capData <= data;
    end
  end

  // Power-up hold-off counter.
  always_ff @(posedge clk) begin
    if (!rstN || !supplyGood) begin
      pwrCnt <= '0;
    end else if (pwrCnt != PU_MAX) begin
      pwrCnt <= pwrCnt + 1'b1;
    end
  end

  assign ready  = (pwrCnt == PU_MAX);
  assign relEvt = ready && !strobeOn && (pulseCnt == PW_MAX);

  generate
    for (genvar k = 0; k < 3; k++) begin : g_cmdMatch
      assign cmdHit[k] = (capAddr == CMD_ADDR[k]) && (capData == CMD_DATA[k]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadStrobe <= 1'b0;
      loadStore  <= 1'b0;
      evtAddr    <= '0;
      evtData    <= '0;
    end else begin
      loadStrobe <= ctl.issue;
      loadStore  <= ctl.issue && ctl.store;
      if (ctl.issue) begin
        evtAddr <= capAddr;
        evtData <= capData;
      end
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);  // R9
  AST_SUPPLY_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> !ready);  // R2
  AST_NO_WRITE_IN_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> !loadStrobe);  // R2
endmodule

// File: rtl/unlock_seq_control.sv
module unlock_seq_control
  import unlock_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        relEvt,
  input  logic [2:0]  cmdHit,
  input  logic        ready,
  input  logic        loadCommit,
  output ctlStrobes_t ctl,
  output logic        unlocked
);
  seqState_e state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (!ready) begin
      nextState = SEQ_STEP0;
    end else begin
      if (relEvt) begin
        unique case (state)
          SEQ_STEP0: begin
            if (cmdHit[0]) nextState = SEQ_STEP1;
            else           ctl.issue = 1'b1;
          end
          SEQ_STEP1: begin
            if (cmdHit[1]) nextState = SEQ_STEP2;
            else begin
              ctl.issue = 1'b1;
              nextState = SEQ_STEP0;
            end
          end
          SEQ_STEP2: begin
            if (cmdHit[2]) nextState = SEQ_OPEN;
            else begin
              ctl.issue = 1'b1;
              nextState = SEQ_STEP0;
            end
          end
          SEQ_OPEN: begin
            ctl.issue = 1'b1;
            ctl.store = 1'b1;
          end
          default: nextState = SEQ_STEP0;
        endcase
      end
      if (state == SEQ_OPEN && loadCommit) nextState = SEQ_STEP0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_STEP0;
    else       state <= nextState;
  end

  assign unlocked = (state == SEQ_OPEN);

  AST_OPEN_NEEDS_THIRD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(relEvt && cmdHit[2] && ready));  // R5
  AST_RELOCK_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(unlocked) |-> $past(loadCommit || !ready));  // R8
  AST_STORE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.store |-> (unlocked && ctl.issue));  // R7
endmodule

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 2,
  parameter int PWRUP_CYC  = 625000,
  parameter logic [2:0][ADDR_W-1:0] CMD_ADDR = {17'h05555, 17'h02AAA, 17'h05555},
  parameter logic [2:0][DATA_W-1:0] CMD_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              loadCommit,
  output logic              unlocked,
  output logic              loadStrobe,
  output logic              loadStore,
  output logic [ADDR_W-1:0] evtAddr,
  output logic [DATA_W-1:0] evtData
);
  ctlStrobes_t ctl;
  logic        relEvt;
  logic [2:0]  cmdHit;
  logic        ready;

  unlock_seq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC),
    .PWRUP_CYC(PWRUP_CYC), .CMD_ADDR(CMD_ADDR), .CMD_DATA(CMD_DATA)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood),
    .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr), .data(data),
    .ctl(ctl), .relEvt(relEvt), .cmdHit(cmdHit), .ready(ready),
    .loadStrobe(loadStrobe), .loadStore(loadStore),
    .evtAddr(evtAddr), .evtData(evtData)
  );

  unlock_seq_control u_control (
    .clk(clk), .rstN(rstN), .relEvt(relEvt), .cmdHit(cmdHit),
    .ready(ready), .loadCommit(loadCommit), .ctl(ctl), .unlocked(unlocked)
  );
endmodule

// File: tb/unlock_seq_detector_bench.sv
module unlock_seq_detector_bench;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int GL = 2;
  localparam int PU = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic loadCommit = 1'b0;
  logic unlocked, loadStrobe, loadStore;
  logic [AW-1:0] evtAddr;
  logic [DW-1:0] evtData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  unlock_seq_detector #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(GL), .PWRUP_CYC(PU))
    u_unlock_seq_detector (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .ceN(ceN), .weN(weN),
    .oeN(oeN), .addr(addr), .data(data), .loadCommit(loadCommit),
    .unlocked(unlocked), .loadStrobe(loadStrobe), .loadStore(loadStore),
    .evtAddr(evtAddr), .evtData(evtData));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive a strobe for width cycles; returns at the negedge where it ends.
  task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int width);
    addr = a; data = d; ceN = 1'b0; weN = 1'b0;
    repeat (width) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  // Write, then check the loader handshake one cycle after release.
  task automatic wrChk(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int width, input bit expStrobe, input bit expStore,
                       input string tag);
    pulse(a, d, width);
    @(negedge clk);
    chk(loadStrobe == expStrobe, tag, 32'(loadStrobe), 32'(expStrobe));
    if (expStrobe) begin
      chk(loadStore == expStore, tag, 32'(loadStore), 32'(expStore));
      chk(evtAddr == a && evtData == d, {tag, " R10 evt"},
          {7'd0, evtAddr, evtData}, {7'd0, a, d});
    end
    @(negedge clk);
    chk(loadStrobe == 1'b0, "R9 strobe width", 32'(loadStrobe), 32'd0);
  endtask

  task automatic unlockSeq(input string tag);
    wrChk(17'h05555, 8'hAA, GL, 1'b0, 1'b0, tag);
    wrChk(17'h02AAA, 8'h55, GL, 1'b0, 1'b0, tag);
    wrChk(17'h05555, 8'hA0, GL, 1'b0, 1'b0, tag);
    chk(unlocked == 1'b1, {tag, " unlocked"}, 32'(unlocked), 32'd1);
  endtask

  task automatic commit();
    loadCommit = 1'b1;
    @(negedge clk);
    loadCommit = 1'b0;
    chk(unlocked == 1'b0, "R8 relock", 32'(unlocked), 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-1:0] badA;
    logic [DW-1:0] badD;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(unlocked == 1'b0 && loadStrobe == 1'b0, "R1 reset",
        {30'd0, unlocked, loadStrobe}, 32'd0);

    // R2: commands and a data write inside the hold-off do nothing.
    wrChk(17'h00100, 8'h11, GL, 1'b0, 1'b0, "R2 supply low");
    supplyGood = 1'b1;
    wrChk(17'h05555, 8'hAA, GL, 1'b0, 1'b0, "R2 holdoff cmd0");
    wrChk(17'h02AAA, 8'h55, GL, 1'b0, 1'b0, "R2 holdoff cmd1");
    wrChk(17'h05555, 8'hA0, GL, 1'b0, 1'b0, "R2 holdoff cmd2");
    chk(unlocked == 1'b0, "R2 holdoff unlocked", 32'(unlocked), 32'd0);
    repeat (PU) @(negedge clk);
    wrChk(17'h00123, 8'h5A, GL, 1'b1, 1'b0, "R2 after holdoff R6");

    // R3: pulse width sweep around the filter threshold.
    for (int w = 1; w <= 4; w++)
      wrChk(AW'(w * 17'h01111), DW'(w * 13), w, w >= GL, 1'b0, "R3 width");

    // R4: output enable dropping mid-strobe cancels the write.
    addr = 17'h00777; data = 8'h33; ceN = 1'b0; weN = 1'b0;
    repeat (3) @(negedge clk);
    oeN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    oeN = 1'b1;
    chk(loadStrobe == 1'b0, "R4 oe cancel", 32'(loadStrobe), 32'd0);
    @(negedge clk);
    chk(loadStrobe == 1'b0, "R4 oe cancel late", 32'(loadStrobe), 32'd0);

    // R5 and R7: unlock, then a sweep of data writes stores each one.
    unlockSeq("R5 seq");
    for (int k = 0; k < 8; k++)
      wrChk(AW'(k * 17'h03111), DW'(k * 37 + 1), GL + (k % 2), 1'b1, 1'b1,
            "R7 store");
    chk(unlocked == 1'b1, "R7 still open", 32'(unlocked), 32'd1);

    // R8: commit re-locks; next write is timer only.
    commit();
    wrChk(17'h01000, 8'hC3, GL, 1'b1, 1'b0, "R8 after commit");

    // R6: break the preamble at every step, by address or by data.
    for (int s = 0; s < 3; s++) begin
      for (int kind = 0; kind < 2; kind++) begin
        if (s >= 1) wrChk(17'h05555, 8'hAA, GL, 1'b0, 1'b0, "R6 prefix0");
        if (s >= 2) wrChk(17'h02AAA, 8'h55, GL, 1'b0, 1'b0, "R6 prefix1");
        badA = (s == 1) ? 17'h02AAA : 17'h05555;
        badD = (s == 0) ? 8'hAA : (s == 1) ? 8'h55 : 8'hA0;
        if (kind == 0) badA = badA ^ 17'h00001;
        else           badD = badD ^ 8'h80;
        wrChk(badA, badD, GL, 1'b1, 1'b0, "R6 mismatch");
        chk(unlocked == 1'b0, "R6 locked", 32'(unlocked), 32'd0);
        // Sequence restarts: step two command alone is now a rejected write.
        wrChk(17'h02AAA, 8'h55, GL, 1'b1, 1'b0, "R6 restart");
      end
    end
    unlockSeq("R6 recover R5");
    commit();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule